// File: doc/BRIEF.md
# PCS Management Register File

This block is the management register file for a gigabit PCS that runs either as 1000BASE-X or as SGMII. Software reaches it through a word-addressed slave port. A request is held until the wait-request output drops. The file stores the control command bits, the advertised ability word, a scratch word, a 21-bit auto-negotiation link timer and the interface-mode selection, and drives them to the PCS. The PCS returns its live status, the completion of the commands it was given, and each new partner ability page. The file reflects all of these back to software.

Two kinds of bit clear themselves. The soft-reset and restart-negotiation command bits are set by software and cleared by the PCS completion inputs. The page-received flag is set by the PCS and cleared when software reads the expansion word. A soft reset leaves every stored register value unchanged.

The port handshake is a two-state machine. In state BUS_IDLE, a read or write request raises wait-request and takes transition "take" to BUS_ACK. In BUS_ACK, wait-request is low, read data is driven and the access commits at the closing clock edge. Transition "finish" then always returns the machine to BUS_IDLE.

Top module: `pcs_mgmt_regs`

## Requirements
- R1: Each read or write sees wait-request high in its first cycle and low in its second cycle. Read data is valid in that second cycle and is 0 whenever no read is being acknowledged.
- R2: After reset, the following words read as shown: control (offset 0x00) 0x0000, advertised ability (0x04) 0x01A0, scratch (0x10) 0, both link timer words (0x12, 0x13) 0, interface mode (0x14) 0. The status word (0x01) reads 0x0008 while the PCS inputs are low.
- R3: Writing 1 to control bit 15 sets soft_reset_req, and bit 15 then reads back as 1. Writing 0 to bit 15 does not clear it. A one-cycle rst_done pulse clears it. Other register contents are unchanged across the soft reset.
- R4: Control bits 14 and 12 are read/write and drive loopback_en and an_enable. Writing 1 to bit 9 sets an_restart_req, and an an_restarted pulse clears it.
- R5: Status word bits are: bit 5 = an_done, bit 3 = constant 1, bit 2 = link_up, all other bits 0. Writes to the status word have no effect.
- R6: In the advertised-ability word, only bits [13:12], [8:7] and [5] are stored, and they drive adv_ability. All other bits read 0, so writing 0xFFFF reads back 0x31A0.
- R7: A page_valid pulse captures partner_word into offset 0x05 and sets expansion bit 1 (offset 0x06). Expansion bit 0 mirrors partner_an_able.
- R8: A read of offset 0x06 returns the flag and then clears it. If page_valid arrives in the same cycle as that read, the flag stays set.
- R9: Offset 0x02 returns PHY_ID[31:16], 0x03 returns PHY_ID[15:0], 0x11 returns REVISION, and the two next-page words (0x07, 0x08) read 0.
- R10: The scratch word at 0x10 stores and returns all 16 bits.
- R11: Offset 0x12 holds link_timer_val[15:0]. Offset 0x13 stores only its low 5 bits as link_timer_val[20:16], and its upper bits read 0.
- R12: Interface-mode bit 0 drives sgmii_mode, bit 1 drives sgmii_auto_speed, and bits [3:2] drive manual_speed. All higher bits read 0.
- R13: Writes to reserved offsets (0x09 to 0x0F and 0x15 to 0x1F) change nothing, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 5 | Word address |
| rd | input | 1 | Read request, held until wait-request is low |
| wr | input | 1 | Write request, held until wait-request is low |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid while rd is high and waitreq is low |
| waitreq | output | 1 | Wait-request |
| rst_done | input | 1 | PCS finished the soft reset |
| an_restarted | input | 1 | PCS began the negotiation restart |
| link_up | input | 1 | Link is established |
| an_done | input | 1 | Auto-negotiation is complete |
| page_valid | input | 1 | New partner ability page on partner_word |
| partner_word | input | 16 | Partner ability page |
| partner_an_able | input | 1 | Partner can auto-negotiate |
| soft_reset_req | output | 1 | Soft reset command to the PCS |
| loopback_en | output | 1 | Serial loopback enable |
| an_enable | output | 1 | Auto-negotiation enable |
| an_restart_req | output | 1 | Negotiation restart command |
| adv_ability | output | 16 | Advertised ability word |
| sgmii_mode | output | 1 | 1 = SGMII, 0 = 1000BASE-X |
| sgmii_auto_speed | output | 1 | Take the speed from negotiation |
| manual_speed | output | 2 | Manual speed code |
| link_timer_val | output | 21 | Link timer value |

## Verification
The bench targets the self-clearing edges.

- A command bit that a later write of 0 cleared would lose a pending soft reset.
- A page flag whose clear beat its set would drop a partner page that arrived during the expansion read.
- A flag that cleared before the read would return 0 to software.
- A timer upper word that was not masked, or was decoded at the wrong offset, would show up as wrong readback or a wrong link_timer_val.
- Writes to reserved and read-only offsets are followed by reads of the neighbouring registers and the outputs, so that a stray write decode is caught.

// File: rtl/pcs_mgmt_pkg.sv
package pcs_mgmt_pkg;

    localparam int REG_W = 16;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_ACK  = 1'b1
    } bus_state_e;

    localparam int OFS_CTRL     = 'h00;
    localparam int OFS_STAT     = 'h01;
    localparam int OFS_ID_HI    = 'h02;
    localparam int OFS_ID_LO    = 'h03;
    localparam int OFS_ADV      = 'h04;
    localparam int OFS_PARTNER  = 'h05;
    localparam int OFS_EXPAND   = 'h06;
    localparam int OFS_NP_TX    = 'h07;
    localparam int OFS_NP_RX    = 'h08;
    localparam int OFS_SCRATCH  = 'h10;
    localparam int OFS_REV      = 'h11;
    localparam int OFS_TMR_LO   = 'h12;
    localparam int OFS_TMR_HI   = 'h13;
    localparam int OFS_IFMODE   = 'h14;

    localparam int CB_SOFT_RST  = 15;
    localparam int CB_LOOPBACK  = 14;
    localparam int CB_AN_EN     = 12;
    localparam int CB_AN_RESTART = 9;

    localparam logic [REG_W-1:0] ADV_MASK  = 16'h31A0;
    localparam logic [REG_W-1:0] ADV_RESET = 16'h01A0;

endpackage

// File: rtl/pcs_bus_fsm.sv
module pcs_bus_fsm
    import pcs_mgmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd,
    input  logic wr,
    output logic waitreq,
    output logic rd_fire,
    output logic wr_fire
);

    bus_state_e state_q, state_d;
    logic       req;

    assign req = rd | wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        waitreq = 1'b0;
        rd_fire = 1'b0;
        wr_fire = 1'b0;
        unique case (state_q)
            BUS_IDLE: begin
                waitreq = req;
                if (req) begin
                    state_d = BUS_ACK;
                end
            end
            BUS_ACK: begin
                rd_fire = rd;
                wr_fire = wr;
                state_d = BUS_IDLE;
            end
        endcase
    end

    assert_wait_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req && waitreq) |=> !waitreq);

    assert_fire_needs_wait_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire || wr_fire) |-> $past(waitreq));

endmodule

// File: rtl/pcs_ctrl_cmd.sv
module pcs_ctrl_cmd
    import pcs_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             rst_done,
    input  logic             an_restarted,
    output logic [REG_W-1:0] ctrl_word,
    output logic             soft_reset_req,
    output logic             loopback_en,
    output logic             an_enable,
    output logic             an_restart_req
);

    logic rst_q, loop_q, anen_q, restart_q;
    logic set_rst, set_restart;

    assign set_rst     = wr_en & wdata[CB_SOFT_RST];
    assign set_restart = wr_en & wdata[CB_AN_RESTART];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_q     <= 1'b0;
            loop_q    <= 1'b0;
            anen_q    <= 1'b0;
            restart_q <= 1'b0;
        end else begin
            if (wr_en) begin
                loop_q <= wdata[CB_LOOPBACK];
                anen_q <= wdata[CB_AN_EN];
            end
            if (set_rst) begin
                rst_q <= 1'b1;
            end else if (rst_done) begin
                rst_q <= 1'b0;
            end
            if (set_restart) begin
                restart_q <= 1'b1;
            end else if (an_restarted) begin
                restart_q <= 1'b0;
            end
        end
    end

    always_comb begin
        ctrl_word                = '0;
        ctrl_word[CB_SOFT_RST]   = rst_q;
        ctrl_word[CB_LOOPBACK]   = loop_q;
        ctrl_word[CB_AN_EN]      = anen_q;
        ctrl_word[CB_AN_RESTART] = restart_q;
    end

    assign soft_reset_req = rst_q;
    assign loopback_en    = loop_q;
    assign an_enable      = anen_q;
    assign an_restart_req = restart_q;

    assert_reset_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_done && !set_rst) |=> !soft_reset_req);

    assert_reset_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_reset_req && !rst_done) |=> soft_reset_req);

    assert_restart_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (an_restarted && !set_restart) |=> !an_restart_req);

endmodule

// File: rtl/pcs_page_tracker.sv
module pcs_page_tracker
    import pcs_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             page_valid,
    input  logic [REG_W-1:0] partner_word,
    input  logic             rd_clear,
    output logic [REG_W-1:0] partner_q,
    output logic             page_flag
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            partner_q <= '0;
            page_flag <= 1'b0;
        end else begin
            if (page_valid) begin
                partner_q <= partner_word;
                page_flag <= 1'b1;
            end else if (rd_clear) begin
                page_flag <= 1'b0;
            end
        end
    end

    assert_page_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        page_valid |=> page_flag);

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clear && !page_valid) |=> !page_flag);

    assert_flag_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (page_flag && !rd_clear) |=> page_flag);

endmodule

// File: rtl/pcs_mgmt_regs.sv
module pcs_mgmt_regs
    import pcs_mgmt_pkg::*;
#(
    parameter int          ADDR_W   = 5,
    parameter int          TIMER_W  = 21,
    parameter logic [31:0] PHY_ID   = 32'h1A2B_3C4D,
    parameter logic [15:0] REVISION = 16'h0107
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                rd,
    input  logic                wr,
    input  logic [REG_W-1:0]    wdata,
    output logic [REG_W-1:0]    rdata,
    output logic                waitreq,
    input  logic                rst_done,
    input  logic                an_restarted,
    input  logic                link_up,
    input  logic                an_done,
    input  logic                page_valid,
    input  logic [REG_W-1:0]    partner_word,
    input  logic                partner_an_able,
    output logic                soft_reset_req,
    output logic                loopback_en,
    output logic                an_enable,
    output logic                an_restart_req,
    output logic [REG_W-1:0]    adv_ability,
    output logic                sgmii_mode,
    output logic                sgmii_auto_speed,
    output logic [1:0]          manual_speed,
    output logic [TIMER_W-1:0]  link_timer_val
);

    localparam int TMR_HI_W = TIMER_W - REG_W;

    logic                rd_fire, wr_fire;
    logic [REG_W-1:0]    ctrl_word, partner_q, status_word, expand_word;
    logic                page_flag;
    logic [REG_W-1:0]    adv_q, scratch_q, tmr_lo_q;
    logic [TMR_HI_W-1:0] tmr_hi_q;
    logic [3:0]          ifmode_q;
    logic [REG_W-1:0]    mux_d;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
        return a == ADDR_W'(ofs);
    endfunction

    pcs_bus_fsm u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd      (rd),
        .wr      (wr),
        .waitreq (waitreq),
        .rd_fire (rd_fire),
        .wr_fire (wr_fire)
    );

    pcs_ctrl_cmd u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_fire && hit(addr, OFS_CTRL)),
        .wdata          (wdata),
        .rst_done       (rst_done),
        .an_restarted   (an_restarted),
        .ctrl_word      (ctrl_word),
        .soft_reset_req (soft_reset_req),
        .loopback_en    (loopback_en),
        .an_enable      (an_enable),
        .an_restart_req (an_restart_req)
    );

    pcs_page_tracker u_page (
        .clk          (clk),
        .rst_n        (rst_n),
        .page_valid   (page_valid),
        .partner_word (partner_word),
        .rd_clear     (rd_fire && hit(addr, OFS_EXPAND)),
        .partner_q    (partner_q),
        .page_flag    (page_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adv_q     <= ADV_RESET;
            scratch_q <= '0;
            tmr_lo_q  <= '0;
            tmr_hi_q  <= '0;
            ifmode_q  <= '0;
        end else if (wr_fire) begin
            if (hit(addr, OFS_ADV))     adv_q     <= wdata & ADV_MASK;
            if (hit(addr, OFS_SCRATCH)) scratch_q <= wdata;
            if (hit(addr, OFS_TMR_LO))  tmr_lo_q  <= wdata;
            if (hit(addr, OFS_TMR_HI))  tmr_hi_q  <= wdata[TMR_HI_W-1:0];
            if (hit(addr, OFS_IFMODE))  ifmode_q  <= wdata[3:0];
        end
    end

    always_comb begin
        status_word    = '0;
        status_word[5] = an_done;
        status_word[3] = 1'b1;
        status_word[2] = link_up;
        expand_word    = '0;
        expand_word[1] = page_flag;
        expand_word[0] = partner_an_able;
    end

    always_comb begin
        mux_d = '0;
        case (int'(addr))
            OFS_CTRL:    mux_d = ctrl_word;
            OFS_STAT:    mux_d = status_word;
            OFS_ID_HI:   mux_d = PHY_ID[31:16];
            OFS_ID_LO:   mux_d = PHY_ID[15:0];
            OFS_ADV:     mux_d = adv_q;
            OFS_PARTNER: mux_d = partner_q;
            OFS_EXPAND:  mux_d = expand_word;
            OFS_NP_TX:   mux_d = '0;
            OFS_NP_RX:   mux_d = '0;
            OFS_SCRATCH: mux_d = scratch_q;
            OFS_REV:     mux_d = REVISION;
            OFS_TMR_LO:  mux_d = tmr_lo_q;
            OFS_TMR_HI:  mux_d = REG_W'(tmr_hi_q);
            OFS_IFMODE:  mux_d = REG_W'(ifmode_q);
            default:     mux_d = '0;
        endcase
    end

    assign rdata            = rd_fire ? mux_d : '0;
    assign adv_ability      = adv_q;
    assign sgmii_mode       = ifmode_q[0];
    assign sgmii_auto_speed = ifmode_q[1];
    assign manual_speed     = ifmode_q[3:2];
    assign link_timer_val   = {tmr_hi_q, tmr_lo_q};

    assert_timer_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_fire |=> $stable(link_timer_val));

    assert_adv_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_fire |=> $stable(adv_ability));

    assert_idle_rdata_R1: assert property (@(posedge clk) disable iff (!rst_n)
        waitreq |-> rdata == '0);

endmodule

// File: tb/test_pcs_mgmt_regs.sv
module test_pcs_mgmt_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        waitreq;
    logic        rst_done = 1'b0, an_restarted = 1'b0;
    logic        link_up = 1'b0, an_done = 1'b0;
    logic        page_valid = 1'b0, partner_an_able = 1'b0;
    logic [15:0] partner_word = '0;
    logic        soft_reset_req, loopback_en, an_enable, an_restart_req;
    logic [15:0] adv_ability;
    logic        sgmii_mode, sgmii_auto_speed;
    logic [1:0]  manual_speed;
    logic [20:0] link_timer_val;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    pcs_mgmt_regs i_pcs_mgmt_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr),
        .wdata(wdata), .rdata(rdata), .waitreq(waitreq),
        .rst_done(rst_done), .an_restarted(an_restarted),
        .link_up(link_up), .an_done(an_done), .page_valid(page_valid),
        .partner_word(partner_word), .partner_an_able(partner_an_able),
        .soft_reset_req(soft_reset_req), .loopback_en(loopback_en),
        .an_enable(an_enable), .an_restart_req(an_restart_req),
        .adv_ability(adv_ability), .sgmii_mode(sgmii_mode),
        .sgmii_auto_speed(sgmii_auto_speed), .manual_speed(manual_speed),
        .link_timer_val(link_timer_val)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // monitor: compare acknowledged read data against the scoreboard
    always @(negedge clk) begin
        if (rst_n && rd && !waitreq) begin
            if (exp_q.size() == 0) begin
                chk("R1 unexpected read ack", 32'(rdata), 32'hFFFF_FFFF);
            end else begin
                chk(tag_q.pop_front(), 32'(rdata), 32'(exp_q.pop_front()));
            end
        end
    end

    task automatic access(bit is_wr, logic [4:0] a, logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; rd = !is_wr; wr = is_wr;
        #1;
        chk("R1 waitreq first cycle", 32'(waitreq), 32'h1);
        @(negedge clk);
        chk("R1 waitreq second cycle", 32'(waitreq), 32'h0);
        @(posedge clk);
        #1;
        rd = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_wr(logic [4:0] a, logic [15:0] d);
        access(1'b1, a, d);
    endtask

    task automatic bus_rd(logic [4:0] a, logic [15:0] expv, string tag);
        exp_q.push_back(expv);
        tag_q.push_back(tag);
        access(1'b0, a, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rdata idle zero", 32'(rdata), 32'h0);

        // R2 reset values
        bus_rd(5'h00, 16'h0000, "R2 control reset");
        bus_rd(5'h01, 16'h0008, "R2 status reset");
        bus_rd(5'h04, 16'h01A0, "R2 adv reset");
        bus_rd(5'h10, 16'h0000, "R2 scratch reset");
        bus_rd(5'h12, 16'h0000, "R2 timer lo reset");
        bus_rd(5'h13, 16'h0000, "R2 timer hi reset");
        bus_rd(5'h14, 16'h0000, "R2 ifmode reset");

        // R10 scratch
        bus_wr(5'h10, 16'hA55A);
        bus_rd(5'h10, 16'hA55A, "R10 scratch pattern 1");
        bus_wr(5'h10, 16'hFFFF);
        bus_rd(5'h10, 16'hFFFF, "R10 scratch pattern 2");

        // R3 soft reset, registers kept
        bus_wr(5'h00, 16'h8000);
        chk("R3 soft_reset_req set", 32'(soft_reset_req), 32'h1);
        bus_rd(5'h00, 16'h8000, "R3 control reads reset bit");
        bus_wr(5'h00, 16'h0000);
        chk("R3 write 0 keeps reset bit", 32'(soft_reset_req), 32'h1);
        @(negedge clk); rst_done = 1'b1;
        @(negedge clk); rst_done = 1'b0;
        chk("R3 soft_reset_req cleared", 32'(soft_reset_req), 32'h0);
        bus_rd(5'h00, 16'h0000, "R3 control after reset done");
        bus_rd(5'h10, 16'hFFFF, "R3 scratch kept over soft reset");

        // R4 loopback, enable, restart
        bus_wr(5'h00, 16'h5200);
        chk("R4 loopback_en", 32'(loopback_en), 32'h1);
        chk("R4 an_enable", 32'(an_enable), 32'h1);
        chk("R4 an_restart_req", 32'(an_restart_req), 32'h1);
        bus_rd(5'h00, 16'h5200, "R4 control readback");
        @(negedge clk); an_restarted = 1'b1;
        @(negedge clk); an_restarted = 1'b0;
        chk("R4 restart cleared", 32'(an_restart_req), 32'h0);
        bus_rd(5'h00, 16'h5000, "R4 control after restart");

        // R5 status
        link_up = 1'b1;
        bus_rd(5'h01, 16'h000C, "R5 status link up");
        an_done = 1'b1;
        bus_rd(5'h01, 16'h002C, "R5 status an done");
        bus_wr(5'h01, 16'h0000);
        bus_rd(5'h01, 16'h002C, "R5 status write ignored");

        // R6 advertised ability mask
        bus_wr(5'h04, 16'hFFFF);
        bus_rd(5'h04, 16'h31A0, "R6 adv masked");
        chk("R6 adv_ability port", 32'(adv_ability), 32'h31A0);
        bus_wr(5'h04, 16'h1020);
        bus_rd(5'h04, 16'h1020, "R6 adv partial");

        // R7 page capture
        partner_an_able = 1'b1;
        bus_rd(5'h06, 16'h0001, "R7 expansion before page");
        @(negedge clk); page_valid = 1'b1; partner_word = 16'hC1E0;
        @(negedge clk); page_valid = 1'b0;
        bus_rd(5'h05, 16'hC1E0, "R7 partner captured");
        bus_rd(5'h06, 16'h0003, "R7 expansion flag set");
        // R8 clear on read
        bus_rd(5'h06, 16'h0001, "R8 flag cleared by read");
        // R8 page arriving during the expansion read
        exp_q.push_back(16'h0001);
        tag_q.push_back("R8 read during new page");
        @(negedge clk); addr = 5'h06; rd = 1'b1;
        @(negedge clk); page_valid = 1'b1; partner_word = 16'h4020;
        @(posedge clk); #1 rd = 1'b0;
        @(negedge clk); page_valid = 1'b0;
        bus_rd(5'h06, 16'h0003, "R8 set wins over clear");
        bus_rd(5'h05, 16'h4020, "R8 second page captured");

        // R9 identity words
        bus_rd(5'h02, 16'h1A2B, "R9 id high");
        bus_rd(5'h03, 16'h3C4D, "R9 id low");
        bus_rd(5'h11, 16'h0107, "R9 revision");
        bus_rd(5'h07, 16'h0000, "R9 next page tx");
        bus_rd(5'h08, 16'h0000, "R9 next page rx");

        // R11 link timer
        bus_wr(5'h12, 16'hBEEF);
        bus_wr(5'h13, 16'hFFFF);
        bus_rd(5'h12, 16'hBEEF, "R11 timer low");
        bus_rd(5'h13, 16'h001F, "R11 timer high masked");
        chk("R11 link_timer_val", 32'(link_timer_val), 32'h1FBEEF);
        bus_wr(5'h13, 16'h0005);
        chk("R11 link_timer_val hi", 32'(link_timer_val), 32'h05BEEF);

        // R12 interface mode
        bus_wr(5'h14, 16'hFFFF);
        bus_rd(5'h14, 16'h000F, "R12 ifmode masked");
        chk("R12 ports all set", {29'b0, sgmii_mode, sgmii_auto_speed, 1'b0} | 32'(manual_speed) << 4,
            32'h36);
        bus_wr(5'h14, 16'h0009);
        chk("R12 sgmii_mode", 32'(sgmii_mode), 32'h1);
        chk("R12 auto speed off", 32'(sgmii_auto_speed), 32'h0);
        chk("R12 manual speed", 32'(manual_speed), 32'h2);

        // R13 reserved offsets
        bus_wr(5'h15, 16'hDEAD);
        bus_wr(5'h09, 16'hDEAD);
        bus_wr(5'h1F, 16'hDEAD);
        bus_rd(5'h15, 16'h0000, "R13 reserved 0x15 reads 0");
        bus_rd(5'h09, 16'h0000, "R13 reserved 0x09 reads 0");
        bus_rd(5'h1F, 16'h0000, "R13 reserved 0x1F reads 0");
        bus_rd(5'h10, 16'hFFFF, "R13 scratch untouched");
        bus_rd(5'h14, 16'h0009, "R13 ifmode untouched");
        bus_rd(5'h04, 16'h1020, "R13 adv untouched");
        chk("R13 timer untouched", 32'(link_timer_val), 32'h05BEEF);

        repeat (3) @(negedge clk);
        chk("R1 scoreboard drained", 32'(exp_q.size()), 32'h0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule